// File: doc/BRIEF.md
# Stop-Clock Power Event Sequencer

This block sequences the host-side handshake for system power events. It holds one 32-bit configuration word made of eight 4-bit groups, one group per event. Each group is a link-stop enable bit above a 3-bit action code. When an event is accepted, the block sends a stop-clock assertion message that carries the event's action code. It then waits for the host's stop-grant indication. If the event's group allows it, the block drives the active-low link-stop output.

On resume, the block first releases link-stop. It waits a minimum gap, set by a parameter, and then sends the matching stop-clock deassertion message. Only one event is in flight at a time. A request that arrives while the block is busy is not taken until the sequence returns to idle. Choosing which event to raise and carrying the messages across the link are left to neighbouring logic.

Event numbers select a group: group g occupies bits [4g+3:4g]. The assignments are 7 for thermal throttle, 6 for normal throttle, 5 for suspend-to-RAM, 4 for the C2 idle state and 3 for voltage/frequency change. Groups 2 to 0 are general purpose.

Top module: `stopclk_seq`

## Requirements
- R1: After synchronous reset the configuration word is 0000_0000h, link_stop_n is 1, msg_valid is 0 and evt_ready is 1.
- R2: A write with cfg_addr equal to CFG_ADDR (default 8'h70) loads the configuration word. Writes to any other address leave it unchanged. Bits 23, 19 and 15 always store and read as 0. cfg_rdata returns the word one cycle after cfg_addr selects CFG_ADDR, and returns 0 for other addresses.
- R3: On the clock edge that accepts a request (evt_req and evt_ready), msg_valid rises with msg_data = {zeros, code, 1}. Here code is bits [4g+2:4g] of event g, placed in msg_data[3:1]. The deassertion message is {zeros, code, 0}. Each message is held stable until the clock edge where msg_ready is high.
- R4: For an event whose link-stop is enabled, link_stop_n falls on the clock edge that samples grant while the block waits for the grant, after the assertion message has been taken. It never falls at any other time.
- R5: When an event's enable bit (bit 4g+3) is 0, link_stop_n stays 1 for the whole sequence.
- R6: For event 4 (C2), link_stop_n never goes low, whatever was written to bit 19.
- R7: For event 3 (voltage/frequency change), link_stop_n always goes low after the grant, even though bit 15 reads 0.
- R8: The clock edge that samples resume in the stopped state sets link_stop_n to 1. The deassertion message becomes valid exactly GAP clock edges later (GAP ≥ 1), so link_stop_n is 1 strictly before that message is offered.
- R9: From acceptance until the deassertion message is taken, evt_ready is 0 and further requests are ignored.
- R10: The action code and enable are captured at acceptance. A configuration write during a sequence changes only later events.
- R11: grant outside the grant-wait state, and resume outside the stopped state, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| evt_req | input | 1 | Event request valid |
| evt_id | input | 3 | Event number (group index) |
| evt_ready | output | 1 | Sequencer idle, request accepted when high |
| msg_valid | output | 1 | Stop-clock message valid |
| msg_data | output | MSG_W | Stop-clock message: bit 0 assert flag, bits 3:1 action code |
| msg_ready | input | 1 | Message taken |
| grant | input | 1 | Stop-grant seen from host |
| resume | input | 1 | Request to leave the stopped state |
| link_stop_n | output | 1 | Active-low link-stop |

## Verification
The sequence is run for the thermal, normal, suspend, C2 and voltage/frequency events, using one configuration word whose codes and enable bits differ from group to group. This separates per-group selection from any fixed mapping, and shows the forced-off and forced-on cases apart from the ordinary enable bit. Every run also includes a stray resume while the block waits for the grant, an extra request while it is stopped, and a stall on the assertion message. Together these show that out-of-state inputs are ignored and that messages are held. A configuration rewrite in mid-sequence, followed by a repeat of the same event, tells capture-at-acceptance apart from a live read. The release-to-message distance is measured with a gap larger than one.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
  localparam int NUM_GROUPS = 8;
  localparam int GROUP_W    = 4;
  localparam int CODE_W     = 3;
  localparam int CFG_W      = NUM_GROUPS * GROUP_W;
  localparam int ID_W       = $clog2(NUM_GROUPS);

  localparam int EVT_THERMAL = 7;
  localparam int EVT_NORMAL  = 6;
  localparam int EVT_STR     = 5;
  localparam int EVT_C2      = 4;
  localparam int EVT_VF      = 3;

  // enable bits that are reserved: suspend, C2, voltage/frequency
  localparam logic [CFG_W-1:0] RSV_MASK =
    (CFG_W'(1) << (EVT_STR*GROUP_W + CODE_W)) |
    (CFG_W'(1) << (EVT_C2*GROUP_W + CODE_W))  |
    (CFG_W'(1) << (EVT_VF*GROUP_W + CODE_W));

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SEND_ON,
    SQ_WAIT_GRANT,
    SQ_STOPPED,
    SQ_RELEASE,
    SQ_SEND_OFF
  } seq_state_t;
endpackage

// File: rtl/stopclk_cfg_reg.sv
module stopclk_cfg_reg
  import stopclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h70
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CFG_W-1:0] rdata
);
  logic hit;
  assign hit = (addr == CFG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      rdata <= '0;
    end else begin
      rdata <= hit ? cfg_q : '0;
      if (we && hit) cfg_q <= wdata & ~RSV_MASK;
    end
  end

  assert_rsv_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rdata & RSV_MASK) == '0);

  assert_other_addr_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (we && !hit) |=> $stable(cfg_q));
endmodule

// File: rtl/stopclk_evt_select.sv
module stopclk_evt_select
  import stopclk_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg,
  input  logic [ID_W-1:0]   evt_id,
  output logic [CODE_W-1:0] sel_code,
  output logic              sel_ls_en
);
  logic [NUM_GROUPS-1:0]        en_vec;
  logic [NUM_GROUPS*CODE_W-1:0] code_vec;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign code_vec[g*CODE_W +: CODE_W] = cfg[g*GROUP_W +: CODE_W];
    if (g == EVT_VF) begin : g_force_on
      assign en_vec[g] = 1'b1;
    end else if (g == EVT_C2 || g == EVT_STR) begin : g_force_off
      assign en_vec[g] = 1'b0;
    end else begin : g_prog
      assign en_vec[g] = cfg[g*GROUP_W + CODE_W];
    end
  end

  assign sel_code  = code_vec[evt_id*CODE_W +: CODE_W];
  assign sel_ls_en = en_vec[evt_id];

  always_comb begin
    if (evt_id == ID_W'(EVT_C2))
      assert_c2_no_stop_R6: assert (!sel_ls_en);
    if (evt_id == ID_W'(EVT_VF))
      assert_vf_stop_R7: assert (sel_ls_en);
  end
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
  import stopclk_pkg::*;
#(
  parameter int GAP   = 1,
  parameter int MSG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_req,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              sel_ls_en,
  input  logic              grant,
  input  logic              resume,
  input  logic              msg_ready,
  output logic              evt_ready,
  output logic              msg_valid,
  output logic [MSG_W-1:0]  msg_data,
  output logic              link_stop_n
);
  localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int PAD_W = MSG_W - CODE_W - 1;

  seq_state_t        state;
  logic [CODE_W-1:0] ev_code;
  logic              ev_ls_en;
  logic [CNT_W-1:0]  gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      evt_ready   <= 1'b1;
      msg_valid   <= 1'b0;
      msg_data    <= '0;
      link_stop_n <= 1'b1;
      ev_code     <= '0;
      ev_ls_en    <= 1'b0;
      gap_cnt     <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (evt_req) begin
          ev_code   <= sel_code;
          ev_ls_en  <= sel_ls_en;
          evt_ready <= 1'b0;
          msg_valid <= 1'b1;
          msg_data  <= {{PAD_W{1'b0}}, sel_code, 1'b1};
          state     <= SQ_SEND_ON;
        end
        SQ_SEND_ON: if (msg_ready) begin
          msg_valid <= 1'b0;
          state     <= SQ_WAIT_GRANT;
        end
        SQ_WAIT_GRANT: if (grant) begin
          if (ev_ls_en) link_stop_n <= 1'b0;
          state <= SQ_STOPPED;
        end
        SQ_STOPPED: if (resume) begin
          link_stop_n <= 1'b1;
          gap_cnt     <= CNT_W'(GAP - 1);
          state       <= SQ_RELEASE;
        end
        SQ_RELEASE: begin
          if (gap_cnt == '0) begin
            msg_valid <= 1'b1;
            msg_data  <= {{PAD_W{1'b0}}, ev_code, 1'b0};
            state     <= SQ_SEND_OFF;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        SQ_SEND_OFF: if (msg_ready) begin
          msg_valid <= 1'b0;
          evt_ready <= 1'b1;
          state     <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_msg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data)));

  assert_stop_after_grant_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(link_stop_n) |-> ($past(grant) && $past(state == SQ_WAIT_GRANT)));

  assert_stop_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (!ev_ls_en && state != SQ_IDLE) |-> link_stop_n);

  assert_release_first_R8: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_data[0]) |-> link_stop_n);

  assert_one_inflight_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_req && !evt_ready) |=> $stable(ev_code));
endmodule

// File: rtl/stopclk_seq.sv
module stopclk_seq
  import stopclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h70,
  parameter int GAP    = 1,
  parameter int MSG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              evt_req,
  input  logic [2:0]        evt_id,
  output logic              evt_ready,
  output logic              msg_valid,
  output logic [MSG_W-1:0]  msg_data,
  input  logic              msg_ready,
  input  logic              grant,
  input  logic              resume,
  output logic              link_stop_n
);
  logic [CFG_W-1:0]  cfg_q;
  logic [CODE_W-1:0] sel_code;
  logic              sel_ls_en;

  stopclk_cfg_reg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg_q(cfg_q), .rdata(cfg_rdata)
  );

  stopclk_evt_select u_sel (
    .cfg(cfg_q), .evt_id(evt_id), .sel_code(sel_code), .sel_ls_en(sel_ls_en)
  );

  stopclk_fsm #(.GAP(GAP), .MSG_W(MSG_W)) u_fsm (
    .clk(clk), .rst(rst), .evt_req(evt_req), .sel_code(sel_code),
    .sel_ls_en(sel_ls_en), .grant(grant), .resume(resume),
    .msg_ready(msg_ready), .evt_ready(evt_ready), .msg_valid(msg_valid),
    .msg_data(msg_data), .link_stop_n(link_stop_n)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (link_stop_n && !msg_valid && evt_ready && cfg_rdata == '0));
endmodule

// File: tb/stopclk_seq_test.sv
module stopclk_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 3;
  localparam logic [7:0] CFG_A = 8'h70;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic evt_req = 0;
  logic [2:0] evt_id = 0;
  logic evt_ready, msg_valid, msg_ready = 0, grant = 0, resume = 0, link_stop_n;
  logic [7:0] msg_data;

  int tests = 0, fails = 0;
  bit chk_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stopclk_seq #(.GAP(GAP)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_req(evt_req),
    .evt_id(evt_id), .evt_ready(evt_ready), .msg_valid(msg_valid),
    .msg_data(msg_data), .msg_ready(msg_ready), .grant(grant),
    .resume(resume), .link_stop_n(link_stop_n)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_cfg;
  int m_st, m_code, m_en, m_cnt, m_lsn, m_v, m_d, m_rd;
  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_st = 0; m_lsn = 1; m_v = 0; m_d = 0; m_rd = 0; m_code = 0; m_en = 0;
    end else begin
      m_rd = (cfg_addr == CFG_A) ? int'(m_cfg) : 0;
      case (m_st)
        0: if (evt_req) begin
          m_code = int'((m_cfg >> (4*evt_id)) & 32'h7);
          if (evt_id == 3) m_en = 1;
          else if (evt_id == 4 || evt_id == 5) m_en = 0;
          else m_en = int'((m_cfg >> (4*evt_id + 3)) & 32'h1);
          m_v = 1; m_d = m_code*2 + 1; m_st = 1;
        end
        1: if (msg_ready) begin m_v = 0; m_st = 2; end
        2: if (grant) begin if (m_en != 0) m_lsn = 0; m_st = 3; end
        3: if (resume) begin m_lsn = 1; m_cnt = GAP - 1; m_st = 4; end
        4: if (m_cnt == 0) begin m_v = 1; m_d = m_code*2; m_st = 5; end
           else m_cnt--;
        5: if (msg_ready) begin m_v = 0; m_st = 0; end
        default: m_st = 0;
      endcase
      if (cfg_we && cfg_addr == CFG_A) m_cfg = cfg_wdata & ~32'h0088_8000;
    end
  end

  always @(negedge clk) if (chk_on) begin
    check(link_stop_n == m_lsn[0], "R4 model link_stop_n", link_stop_n, m_lsn);
    check(msg_valid == m_v[0], "R3 model msg_valid", msg_valid, m_v);
    check(!m_v[0] || msg_data == m_d[7:0], "R3 model msg_data", msg_data, m_d);
    check(evt_ready == (m_st == 0), "R9 model evt_ready", evt_ready, m_st == 0);
    check(cfg_rdata == m_rd, "R2 model cfg_rdata", cfg_rdata, m_rd);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; cfg_addr = 0;
  endtask

  task automatic rd_check(input logic [31:0] exp, input string tag);
    cfg_addr = CFG_A; @(negedge clk);
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
    cfg_addr = 0;
  endtask

  task automatic do_event(input int id, input int code, input bit stop,
                          input bit mid_wr, input logic [31:0] wval);
    evt_req = 1; evt_id = 3'(id);
    @(negedge clk); evt_req = 0;
    check(msg_valid && msg_data == 8'(code*2 + 1), "R3 assert msg", msg_data, code*2 + 1);
    @(negedge clk); msg_ready = 1;          // one stalled cycle first
    @(negedge clk); msg_ready = 0;
    resume = 1;                              // stray resume while waiting for grant
    @(negedge clk); resume = 0;
    check(!msg_valid && link_stop_n, "R11 stray resume", {msg_valid, link_stop_n}, 2'b01);
    grant = 1;
    @(negedge clk); grant = 0;
    check(link_stop_n == !stop, stop ? "R4/R7 stop after grant" : "R5/R6 no stop",
          link_stop_n, !stop);
    evt_req = 1; evt_id = 0;
    if (mid_wr) begin cfg_we = 1; cfg_addr = CFG_A; cfg_wdata = wval; end
    @(negedge clk); evt_req = 0; cfg_we = 0; cfg_addr = 0;
    check(!evt_ready, "R9 busy", evt_ready, 0);
    resume = 1; msg_ready = 1;
    @(negedge clk); resume = 0;
    begin
      int k = 1;
      while (!msg_valid && k < 50) begin @(negedge clk); k++; end
      check(k == GAP + 1 && link_stop_n, "R8 release gap", k, GAP + 1);
    end
    check(msg_data == 8'(code*2), "R10 deassert msg code", msg_data, code*2);
    @(negedge clk); msg_ready = 0;
    check(evt_ready, "R9 idle again", evt_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(link_stop_n && !msg_valid && evt_ready, "R1 reset outputs",
          {link_stop_n, msg_valid, evt_ready}, 3'b101);
    chk_on = 1;
    rd_check(32'h0, "R1 reset cfg");
    wr(CFG_A, 32'hFFFF_FFFF);
    rd_check(32'hFF77_7FFF, "R2 reserved bits");
    wr(8'h74, 32'h0);
    rd_check(32'hFF77_7FFF, "R2 other address");
    wr(CFG_A, 32'hD3EA_790C);
    rd_check(32'hD362_790C, "R2 config word");
    grant = 1; @(negedge clk); grant = 0;    // stray grant while idle
    check(link_stop_n && evt_ready, "R11 stray grant", link_stop_n, 1);
    do_event(7, 5, 1, 1, 32'h1362_790C);     // thermal, rewrite mid-sequence
    do_event(7, 1, 0, 0, 0);                 // rewrite now visible
    do_event(6, 3, 0, 0, 0);                 // normal, enable off
    do_event(4, 2, 0, 0, 0);                 // C2 forced off
    do_event(3, 7, 1, 0, 0);                 // voltage/frequency forced on
    do_event(5, 6, 0, 0, 0);                 // suspend
    do_event(2, 1, 1, 0, 0);                 // general group, enabled
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule